// File: doc/BRIEF.md
# Expansion I/O Port Bridge

This block sits between an on-chip transfer-request interface and an external I/O port bus. The port bus has several chip-enable spaces, a 4-bit word address and a 32-bit data bus. Each request carries:

- the identity of the requester;
- a flag telling whether the other end of the transfer also lies in the port's spaces;
- an element size of 8, 16 or 32 bits;
- a direction;
- a frame-start flag;
- a space select;
- a byte address;
- write data.

The block checks each request first. A request that breaks the access rules is answered with an error and produces no external cycle. A legal request becomes one external access. The chip enable of the selected space is held for a fixed, parameterised number of clocks. During the access the block presents the word address and the direction, and it drives byte enables and write data on the lanes that match the element size and the low address bits. On reads it takes the selected lane from the bus and returns it right-justified. When a request opens a new frame, one idle cycle with every chip enable low comes before the access. This lets a different peripheral take over the data bus without contention.

Top module: `xio_bridge`

## Requirements
- R1: A request whose `req_master` is 4 or above is refused. Only codes 0 to 3, the transfer-engine channels, are allowed. A refused request gets a response with `rsp_err`=1, and no chip enable is asserted for it.
- R2: A request with `req_peer_xspace`=1, meaning a transfer from one port space to another, is refused in the same way as R1.
- R3: The size codes are 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. The following requests are refused in the same way as R1:
  - a size code of 3;
  - a 32-bit request whose address bits [1:0] are not 00;
  - a 16-bit request whose address bit 0 is 1.
- R4: Timing of a legal request that does not open a frame:
  - its access holds a chip enable for exactly STROBE cycles, starting in the cycle after acceptance;
  - `rsp_valid`=1 with `rsp_err`=0 for one cycle, the cycle after the last access cycle.
  
  A refused request gives `rsp_valid`=1 in the second cycle after acceptance.
- R5: A legal request with `req_first`=1 is preceded by exactly one cycle with all chip enables low, then runs as in R4. A refused request never asserts a chip enable.
- R6: `req_ready` is high when the block is idle and in the last cycle of an access. It is low in the turnaround cycle, in the other access cycles and in the cycle after a refused request is accepted. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R7: During an access, `xp_ce` is one-hot with bit `req_space` set. Outside an access it is all zeros.
- R8: During an access, `xp_addr` equals address bits [5:2] and `xp_wr` equals `req_write`. Outside an access both are zero.
- R9: During an access, `xp_be` and the write lanes follow the element size and address:
  - 8-bit: `xp_be` has only bit A[1:0] set, and the data byte sits on bits 8*A[1:0]+7 down to 8*A[1:0];
  - 16-bit: A[1]=0 gives `xp_be`=0011 with the data on bits 15:0, and A[1]=1 gives 1100 with the data on bits 31:16;
  - 32-bit: `xp_be`=1111 and the whole word is driven.
  
  `xp_be` is zero outside an access.
- R10: On a read response, `rsp_rdata` holds the selected lane of `xp_rdata` as sampled in the last access cycle, right-justified and zero-extended. Lanes that are not selected have no effect. On write responses and error responses `rsp_rdata` is zero.
- R11: `xp_wdata` is zero except during a write access. Within a write access, lanes whose `xp_be` bit is low are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_master | input | 3 | Requester code, 0 to 3 are engine channels |
| req_peer_xspace | input | 1 | Other end of the transfer is also a port space |
| req_size | input | 2 | Element size code |
| req_write | input | 1 | 1 = write to the port, 0 = read |
| req_first | input | 1 | Request opens a new frame |
| req_space | input | $clog2(NSPACE) | Chip-enable space select |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write element, right-justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is a refusal |
| rsp_rdata | output | 32 | Read element, right-justified |
| xp_ce | output | NSPACE | Chip enables, active high |
| xp_addr | output | 4 | External word address |
| xp_wr | output | 1 | Access direction, 1 = write |
| xp_be | output | 4 | Byte-lane enables |
| xp_wdata | output | 32 | Data driven to the port |
| xp_rdata | input | 32 | Data returned by the port |

## Verification
The assertions assume that `req_space` stays below NSPACE, so that a chip-enable bit exists for it. They also assume that the request inputs carry no unknown values while `req_valid` is high. The stimulus meets both assumptions: it uses space codes 0 to 3 with four spaces, and it holds each request steady from the moment it is raised until the edge on which it is taken. Read data comes from a fixed function of `xp_addr`, so it is stable at the sampling edge and differs from lane to lane.

// File: rtl/xio_pkg.sv
package xio_pkg;

    localparam int DATA_W  = 32;
    localparam int NBYTE   = DATA_W / 8;
    localparam int XADDR_W = 4;
    localparam int MID_W   = 3;
    localparam int NCHAN_OK = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xsize_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_BUS  = 2'd2,
        ST_FAIL = 2'd3
    } xstate_e;

    // fields of an accepted request that the bus phase still needs
    typedef struct packed {
        xsize_e              size;
        logic                write;
        logic [5:0]          lo6;
        logic [DATA_W-1:0]   wdata;
    } xbus_t;

endpackage

// File: rtl/xio_gate.sv
module xio_gate
    import xio_pkg::*;
(
    input  logic [MID_W-1:0] master,
    input  logic             peer,
    input  xsize_e           size,
    input  logic [1:0]       lo,
    output logic             bad
);

    logic bad_mid, bad_size, bad_align;

    always_comb begin
        bad_mid  = (master >= MID_W'(NCHAN_OK));
        bad_size = (size == SZ_BAD);
        case (size)
            SZ_WORD: bad_align = (lo != 2'b00);
            SZ_HALF: bad_align = lo[0];
            default: bad_align = 1'b0;
        endcase
        bad = bad_mid | peer | bad_size | bad_align;
    end

endmodule

// File: rtl/xio_lanes.sv
module xio_lanes
    import xio_pkg::*;
(
    input  xsize_e             size,
    input  logic [1:0]         lo,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  rdata_bus,
    output logic [NBYTE-1:0]   be,
    output logic [DATA_W-1:0]  wlane,
    output logic [DATA_W-1:0]  rpick
);

    always_comb begin
        case (size)
            SZ_BYTE: be = NBYTE'(1) << lo;
            SZ_HALF: be = lo[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: be = 4'b1111;
            default: be = 4'b0000;
        endcase
    end

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        localparam logic [1:0] IDX = 2'(b);
        logic [1:0] wsrc;
        logic [1:0] rsrc;
        logic       rkeep;

        always_comb begin
            case (size)
                SZ_BYTE: begin wsrc = 2'd0;            rsrc = lo;              rkeep = (IDX == 2'd0); end
                SZ_HALF: begin wsrc = {1'b0, IDX[0]};  rsrc = {lo[1], IDX[0]}; rkeep = ~IDX[1];       end
                SZ_WORD: begin wsrc = IDX;             rsrc = IDX;             rkeep = 1'b1;          end
                default: begin wsrc = IDX;             rsrc = IDX;             rkeep = 1'b0;          end
            endcase
        end

        assign wlane[b*8 +: 8] = be[b] ? wdata[{wsrc, 3'b000} +: 8] : 8'h00;
        assign rpick[b*8 +: 8] = rkeep ? rdata_bus[{rsrc, 3'b000} +: 8] : 8'h00;
    end

endmodule

// File: rtl/xio_seq.sv
module xio_seq
    import xio_pkg::*;
#(
    parameter int STROBE = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    take,
    input  logic    take_first,
    input  logic    take_bad,
    output xstate_e state,
    output logic    ready,
    output logic    bus_last
);

    localparam int CW = $clog2(STROBE + 1);

    logic [CW-1:0] cnt;

    assign bus_last = (cnt == CW'(STROBE - 1));
    assign ready    = (state == ST_IDLE) || ((state == ST_BUS) && bus_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (take) begin
            cnt <= '0;
            if (take_bad)
                state <= ST_FAIL;
            else if (take_first)
                state <= ST_TURN;
            else
                state <= ST_BUS;
        end else begin
            case (state)
                ST_TURN: begin
                    state <= ST_BUS;
                    cnt   <= '0;
                end
                ST_BUS: begin
                    if (bus_last)
                        state <= ST_IDLE;
                    else
                        cnt <= cnt + 1'b1;
                end
                ST_FAIL: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUS && !bus_last) |=> (state == ST_BUS));

    // R5
    turn_once_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TURN) |=> (state == ST_BUS));

endmodule

// File: rtl/xio_bridge.sv
module xio_bridge
    import xio_pkg::*;
#(
    parameter int NSPACE = 4,
    parameter int STROBE = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [2:0]                 req_master,
    input  logic                       req_peer_xspace,
    input  logic [1:0]                 req_size,
    input  logic                       req_write,
    input  logic                       req_first,
    input  logic [$clog2(NSPACE)-1:0]  req_space,
    input  logic [31:0]                req_addr,
    input  logic [31:0]                req_wdata,
    output logic                       rsp_valid,
    output logic                       rsp_err,
    output logic [31:0]                rsp_rdata,
    output logic [NSPACE-1:0]          xp_ce,
    output logic [3:0]                 xp_addr,
    output logic                       xp_wr,
    output logic [3:0]                 xp_be,
    output logic [31:0]                xp_wdata,
    input  logic [31:0]                xp_rdata
);

    localparam int SEL_W = $clog2(NSPACE);

    xstate_e            state;
    logic               ready, bus_last, fire, bad, bus;
    xbus_t              cur;
    logic [SEL_W-1:0]   cur_space;
    logic [NBYTE-1:0]   lane_be;
    logic [DATA_W-1:0]  lane_wd, lane_rd;

    assign fire      = req_valid & ready;
    assign req_ready = ready;
    assign bus       = (state == ST_BUS);

    xio_gate u_gate (
        .master (req_master),
        .peer   (req_peer_xspace),
        .size   (xsize_e'(req_size)),
        .lo     (req_addr[1:0]),
        .bad    (bad)
    );

    xio_seq #(.STROBE(STROBE)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .take       (fire),
        .take_first (req_first),
        .take_bad   (bad),
        .state      (state),
        .ready      (ready),
        .bus_last   (bus_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            cur_space <= '0;
        end else if (fire) begin
            cur.size  <= xsize_e'(req_size);
            cur.write <= req_write;
            cur.lo6   <= req_addr[5:0];
            cur.wdata <= req_wdata;
            cur_space <= req_space;
        end
    end

    xio_lanes u_lanes (
        .size      (cur.size),
        .lo        (cur.lo6[1:0]),
        .wdata     (cur.wdata),
        .rdata_bus (xp_rdata),
        .be        (lane_be),
        .wlane     (lane_wd),
        .rpick     (lane_rd)
    );

    assign xp_ce    = bus ? (NSPACE'(1) << cur_space) : '0;
    assign xp_addr  = bus ? cur.lo6[5:2] : '0;
    assign xp_wr    = bus & cur.write;
    assign xp_be    = bus ? lane_be : '0;
    assign xp_wdata = (bus && cur.write) ? lane_wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (bus && bus_last) || (state == ST_FAIL);
            rsp_err   <= (state == ST_FAIL);
            rsp_rdata <= (bus && bus_last && !cur.write) ? lane_rd : '0;
        end
    end

    // R7
    ce_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(xp_ce));

    // R5
    turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_first) |=> (xp_ce == '0));

    // R1
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> ($past(xp_ce) == '0));

    // R9
    be_live_chk: assert property (@(posedge clk) disable iff (rst)
        (xp_ce != '0) |-> (xp_be != '0));

    // R11
    dir_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (xp_ce == '0) |-> (xp_wdata == '0 && !xp_wr && xp_be == '0));

    // R6
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_first) |=> (xp_ce != '0 || rsp_valid || !req_ready));

endmodule

// File: tb/test_xio_bridge.sv
`timescale 1ns/1ps
module test_xio_bridge;

    localparam int NSPACE = 4;
    localparam int STROBE = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_peer_xspace, req_write, req_first;
    logic [2:0]  req_master;
    logic [1:0]  req_size;
    logic [1:0]  req_space;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [3:0]  xp_ce;
    logic [3:0]  xp_addr;
    logic        xp_wr;
    logic [3:0]  xp_be;
    logic [31:0] xp_wdata, xp_rdata;

    int ntests = 0;
    int nfail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xio_bridge #(.NSPACE(NSPACE), .STROBE(STROBE)) i_xio_bridge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_master(req_master), .req_peer_xspace(req_peer_xspace),
        .req_size(req_size), .req_write(req_write), .req_first(req_first),
        .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .xp_ce(xp_ce), .xp_addr(xp_addr), .xp_wr(xp_wr), .xp_be(xp_be),
        .xp_wdata(xp_wdata), .xp_rdata(xp_rdata)
    );

    function automatic logic [31:0] pat(logic [3:0] a);
        return 32'h1357_9BDF ^ {a, 4'h0, a, 4'h5, a, 4'hA, a, 4'hF};
    endfunction

    assign xp_rdata = pat(xp_addr);

    function automatic bit legal(int mid, bit peer, int sz, logic [1:0] lo);
        if (mid >= 4) return 0;
        if (peer) return 0;
        if (sz == 3) return 0;
        if (sz == 2 && lo != 2'b00) return 0;
        if (sz == 1 && lo[0]) return 0;
        return 1;
    endfunction

    function automatic string why(int mid, bit peer);
        if (mid >= 4) return "R1";
        if (peer) return "R2";
        return "R3";
    endfunction

    function automatic logic [3:0] ebe(int sz, logic [1:0] lo);
        if (sz == 0) return 4'b0001 << lo;
        if (sz == 1) return lo[1] ? 4'hC : 4'h3;
        return 4'hF;
    endfunction

    function automatic logic [31:0] eplace(int sz, logic [1:0] lo, logic [31:0] d);
        if (sz == 0) return {24'h0, d[7:0]} << (8 * int'(lo));
        if (sz == 1) return {16'h0, d[15:0]} << (16 * int'(lo[1]));
        return d;
    endfunction

    function automatic logic [31:0] epick(int sz, logic [1:0] lo, logic [31:0] r);
        if (sz == 0) return (r >> (8 * int'(lo))) & 32'h0000_00FF;
        if (sz == 1) return (r >> (16 * int'(lo[1]))) & 32'h0000_FFFF;
        return r;
    endfunction

    // behavioural reference: 0 idle, 1 turnaround, 2 access, 3 refusal
    int          m_st = 0;
    int          m_cnt = 0;
    logic [31:0] m_addr = 0, m_wd = 0;
    int          m_size = 0, m_space = 0;
    bit          m_wr = 0;
    string       m_why = "R1";
    string       r_why = "R1";
    bit          e_v = 0, e_e = 0;
    logic [31:0] e_rd = 0;

    function automatic bit m_ready();
        return (m_st == 0) || (m_st == 2 && m_cnt == STROBE - 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; e_v = 0; e_e = 0; e_rd = 0;
        end else begin
            bit rdy;
            rdy = m_ready();
            e_v = 0; e_e = 0; e_rd = 0;
            if (m_st == 2 && m_cnt == STROBE - 1) begin
                e_v = 1;
                e_rd = m_wr ? 32'h0 : epick(m_size, m_addr[1:0], pat(m_addr[5:2]));
            end
            if (m_st == 3) begin
                e_v = 1; e_e = 1; r_why = m_why;
            end
            if (rdy && req_valid) begin
                m_addr = req_addr; m_wd = req_wdata; m_size = int'(req_size);
                m_space = int'(req_space); m_wr = req_write;
                m_cnt = 0;
                if (!legal(int'(req_master), req_peer_xspace, int'(req_size), req_addr[1:0])) begin
                    m_st = 3; m_why = why(int'(req_master), req_peer_xspace);
                end else if (req_first) m_st = 1;
                else m_st = 2;
            end else begin
                case (m_st)
                    1: begin m_st = 2; m_cnt = 0; end
                    2: if (m_cnt == STROBE - 1) m_st = 0; else m_cnt++;
                    3: m_st = 0;
                    default: m_st = 0;
                endcase
            end
        end
    end

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [3:0]  x_ce, x_be;
            logic [31:0] x_wd;
            x_ce = (m_st == 2) ? (4'b0001 << m_space) : 4'h0;
            x_be = (m_st == 2) ? ebe(m_size, m_addr[1:0]) : 4'h0;
            x_wd = (m_st == 2 && m_wr) ? eplace(m_size, m_addr[1:0], m_wd) : 32'h0;
            chk(req_ready == m_ready(), "R6", "req_ready", 32'(req_ready), 32'(m_ready()));
            chk(xp_ce == x_ce, (m_st == 1) ? "R5" : "R7", "xp_ce", 32'(xp_ce), 32'(x_ce));
            chk(xp_addr == ((m_st == 2) ? m_addr[5:2] : 4'h0), "R8", "xp_addr",
                32'(xp_addr), 32'((m_st == 2) ? m_addr[5:2] : 4'h0));
            chk(xp_wr == (m_st == 2 && m_wr), "R8", "xp_wr", 32'(xp_wr), 32'(m_st == 2 && m_wr));
            chk(xp_be == x_be, "R9", "xp_be", 32'(xp_be), 32'(x_be));
            chk(xp_wdata == x_wd, (m_st == 2 && m_wr) ? "R9" : "R11", "xp_wdata", xp_wdata, x_wd);
            chk(rsp_valid == e_v, "R4", "rsp_valid", 32'(rsp_valid), 32'(e_v));
            if (e_v) begin
                chk(rsp_err == e_e, e_e ? r_why : "R4", "rsp_err", 32'(rsp_err), 32'(e_e));
                chk(rsp_rdata == e_rd, "R10", "rsp_rdata", rsp_rdata, e_rd);
            end
        end
    end

    task automatic send(int mid, bit peer, int sz, bit wr, bit first, int sp,
                        logic [31:0] addr, logic [31:0] wd);
        bit got;
        req_master = 3'(mid); req_peer_xspace = peer; req_size = 2'(sz);
        req_write = wr; req_first = first; req_space = 2'(sp);
        req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        do begin
            got = req_ready;
            @(negedge clk);
        end while (!got);
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        nfail++;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 0; req_master = 0; req_peer_xspace = 0; req_size = 0;
        req_write = 0; req_first = 0; req_space = 0; req_addr = 0; req_wdata = 0;
        repeat (3) @(negedge clk);
        // reset state: ready high, no enables, no response
        chk(req_ready == 1'b1, "R6", "reset ready", 32'(req_ready), 32'h1);
        chk(xp_ce == 4'h0, "R7", "reset ce", 32'(xp_ce), 32'h0);
        chk(rsp_valid == 1'b0, "R4", "reset rsp", 32'(rsp_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R9 byte lanes on writes, one frame per space; R5 turnaround
        for (int i = 0; i < 4; i++)
            send(i, 0, 0, 1, (i == 0), i, 32'h1000_0000 | 32'(i) | (32'(i) << 2), 32'hCAFE_00A5 + 32'(i));
        // R9 halfword lanes, back to back without frame start
        send(1, 0, 1, 1, 0, 2, 32'h0000_0000, 32'h1234_BEEF);
        send(1, 0, 1, 1, 0, 2, 32'h0000_0012, 32'h5678_F00D);
        send(2, 0, 2, 1, 1, 3, 32'h0000_003C, 32'hDEAD_BEEF);
        idle(3);
        // R10 reads on every lane and size
        for (int i = 0; i < 4; i++) send(3, 0, 0, 0, (i == 0), 1, 32'h20 | 32'(i), 32'hFFFF_FFFF);
        send(0, 0, 1, 0, 1, 0, 32'h0000_0008, 32'h0);
        send(0, 0, 1, 0, 0, 0, 32'h0000_000A, 32'h0);
        send(0, 0, 2, 0, 0, 0, 32'h0000_0034, 32'h0);
        idle(2);
        // R1 refused requesters
        send(4, 0, 2, 1, 0, 0, 32'h0, 32'h1111_1111);
        send(5, 0, 0, 0, 1, 1, 32'h1, 32'h0);
        send(7, 0, 1, 1, 0, 2, 32'h2, 32'h2222_2222);
        // R2 space to space
        send(0, 1, 2, 0, 0, 3, 32'h4, 32'h0);
        // R3 bad size and misalignment
        send(1, 0, 3, 1, 0, 0, 32'h8, 32'h3333_3333);
        for (int lo = 1; lo < 4; lo++) send(2, 0, 2, 0, 0, 1, 32'h10 | 32'(lo), 32'h0);
        send(2, 0, 1, 1, 0, 1, 32'h11, 32'h4444_4444);
        send(2, 0, 1, 0, 0, 1, 32'h13, 32'h0);
        // a legal access right after a refusal
        send(0, 0, 0, 1, 0, 0, 32'h2B, 32'h0000_0077);
        idle(2);
        // R8 every external address
        for (int a = 0; a < 16; a++) send(a % 4, 0, 2, a[0], (a % 5 == 0), a % 4, 32'(a) << 2, 32'h0F0F_0000 ^ 32'(a));
        idle(2);
        // mixed stream
        for (int n = 0; n < 600; n++) begin
            int mid, sz;
            mid = ($urandom % 6 == 0) ? 4 + int'($urandom % 4) : int'($urandom % 4);
            sz  = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
            send(mid, ($urandom % 10 == 0), sz, $urandom % 2, ($urandom % 4 == 0),
                 int'($urandom % 4), $urandom, $urandom);
            if ($urandom % 3 == 0) idle(int'($urandom % 3));
        end
        idle(10);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule